// File: doc/BRIEF.md
# Zero-Crossing FSK Data Recovery

This block turns a hard-limited receive carrier back into 300-baud binary data. The carrier comes in as a single comparator bit, sampled on the system clock. The block times the gap between successive transitions of that bit, which is one half-period of the incoming tone. It then decides mark or space by comparing the gap against a threshold placed between the two tones of the receive pair in use.

Three inputs choose the receive pair: the signalling standard (Bell-style or V.21-style), the originate/answer role, and analog loopback. In loopback the block listens on its own transmit band. The recovered bit is driven on `rxd`. While the carrier-present input is low, `rxd` is forced to mark. The decision logic keeps running underneath, so the latest decision shows as soon as the carrier returns.

Top module: `fsk_demod`

## Requirements
- R1: After reset the stored decision is mark, so `rxd` reads 1 while `carrier_ok` is 1 and no valid measurement has been taken; the first transition after reset is never used as a measurement.
- R2: Without loopback, originate (`orig_mode`=1) listens on the high band and answer (`orig_mode`=0) on the low band. High band is Bell 2025 space / 2225 mark, V.21 1850 space / 1650 mark. Low band is Bell 1070 space / 1270 mark, V.21 1180 space / 980 mark (Hz).
- R3: With `loopback`=1 the band is swapped, so the block listens on the transmit band of the selected role: the low band for originate and the high band for answer.
- R4: With `v21_sel`=0 (Bell-style), mark is the higher tone. A measured half-period strictly below the threshold gives `rxd`=1, and anything else within the limit gives 0.
- R5: With `v21_sel`=1 (V.21-style), mark is the lower tone. A measured half-period strictly above the threshold gives `rxd`=1, and anything else within the limit gives 0.
- R6: Each tone's half-period is floor(CLK_HZ/(2*f)) cycles. The threshold is floor((space half-period + mark half-period)/2) for the selected pair, and a half-period equal to the threshold counts as space.
- R7: A half-period is the number of clock cycles between successive transitions of `rx_bit` after a two-flop synchroniser. Every accepted measurement replaces the decision, and `rxd` follows three clock edges after the transition is sampled.
- R8: A measurement longer than twice the slower tone's half-period of the selected pair is discarded, leaving the decision unchanged. A measurement exactly equal to that limit is accepted.
- R9: While `carrier_ok`=0, `rxd` is 1 in the same cycle, whatever the decision.
- R10: Measurements keep updating the decision while `carrier_ok`=0, and `rxd` shows the latest decision in the cycle `carrier_ok` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_bit | input | 1 | Hard-limited receive carrier |
| v21_sel | input | 1 | 0 selects Bell-style tones, 1 selects V.21-style tones |
| orig_mode | input | 1 | 1 originate / channel 1, 0 answer / channel 2 |
| loopback | input | 1 | 1 listens on the own transmit band |
| carrier_ok | input | 1 | Carrier present, active high |
| rxd | output | 1 | Recovered data, 1 = mark |

## Verification
The decision update and the carrier clamp can act in the same cycle: a transition may complete a valid measurement while `carrier_ok` is low. The bench provokes this by dropping `carrier_ok` during a space tone and feeding a mark tone while clamped, then doing the reverse. It judges `rxd` to be 1 throughout the clamp, and equal to the tone fed during the clamp on the cycle the carrier returns. Threshold ties and the noise limit are probed with half-periods one cycle either side of each boundary.

// File: rtl/fsk_demod.sv
module fsk_demod #(
  parameter int CLK_HZ        = 1_000_000,
  parameter int BELL_HI_SPACE = 2025,
  parameter int BELL_HI_MARK  = 2225,
  parameter int BELL_LO_SPACE = 1070,
  parameter int BELL_LO_MARK  = 1270,
  parameter int V21_HI_SPACE  = 1850,
  parameter int V21_HI_MARK   = 1650,
  parameter int V21_LO_SPACE  = 1180,
  parameter int V21_LO_MARK   = 980
) (
  input  logic clk,
  input  logic rst,
  input  logic rx_bit,
  input  logic v21_sel,
  input  logic orig_mode,
  input  logic loopback,
  input  logic carrier_ok,
  output logic rxd
);

  function automatic int hp(int f);
    return CLK_HZ / (2 * f);
  endfunction

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  localparam int BH_THR = (hp(BELL_HI_SPACE) + hp(BELL_HI_MARK)) / 2;
  localparam int BL_THR = (hp(BELL_LO_SPACE) + hp(BELL_LO_MARK)) / 2;
  localparam int VH_THR = (hp(V21_HI_SPACE) + hp(V21_HI_MARK)) / 2;
  localparam int VL_THR = (hp(V21_LO_SPACE) + hp(V21_LO_MARK)) / 2;
  localparam int BH_LIM = 2 * mx(hp(BELL_HI_SPACE), hp(BELL_HI_MARK));
  localparam int BL_LIM = 2 * mx(hp(BELL_LO_SPACE), hp(BELL_LO_MARK));
  localparam int VH_LIM = 2 * mx(hp(V21_HI_SPACE), hp(V21_HI_MARK));
  localparam int VL_LIM = 2 * mx(hp(V21_LO_SPACE), hp(V21_LO_MARK));
  localparam int LIM_MAX = mx(mx(BH_LIM, BL_LIM), mx(VH_LIM, VL_LIM));
  localparam int CW = $clog2(LIM_MAX + 2) + 1;
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic          s1, s2, s3;
  logic [CW-1:0] cnt;
  logic          bit_q;
  logic [CW-1:0] thr, lim;
  logic          edge_seen, take, is_mark, band_hi;

  assign band_hi   = orig_mode ^ loopback;
  assign edge_seen = s2 ^ s3;

  always_comb begin
    unique case ({v21_sel, band_hi})
      2'b01:   begin thr = CW'(BH_THR); lim = CW'(BH_LIM); end
      2'b00:   begin thr = CW'(BL_THR); lim = CW'(BL_LIM); end
      2'b11:   begin thr = CW'(VH_THR); lim = CW'(VH_LIM); end
      default: begin thr = CW'(VL_THR); lim = CW'(VL_LIM); end
    endcase
  end

  assign is_mark = v21_sel ? (cnt > thr) : (cnt < thr);
  assign take    = edge_seen && (cnt <= lim);
  assign rxd     = carrier_ok ? bit_q : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1    <= 1'b0;
      s2    <= 1'b0;
      s3    <= 1'b0;
      cnt   <= CNT_MAX;
      bit_q <= 1'b1;
    end else begin
      s1 <= rx_bit;
      s2 <= s1;
      s3 <= s2;
      if (edge_seen)
        cnt <= CW'(1);
      else if (cnt != CNT_MAX)
        cnt <= cnt + CW'(1);
      if (take)
        bit_q <= is_mark;
    end
  end

  AST_DECIDE_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    !edge_seen |=> $stable(bit_q)); // R7

  AST_NOISE_DROP: assert property (@(posedge clk) disable iff (rst)
    (edge_seen && cnt > lim) |=> $stable(bit_q)); // R8

  AST_FALL_NEEDS_CARRIER: assert property (@(posedge clk) disable iff (rst)
    $fell(rxd) |-> carrier_ok); // R9

  AST_RXD_CAUSE: assert property (@(posedge clk) disable iff (rst)
    (carrier_ok && $past(carrier_ok) && rxd != $past(rxd)) |-> $past(take)); // R10

endmodule

// File: tb/tb_fsk_demod.sv
module tb_fsk_demod;
  localparam int CLK_HZ = 200_000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_bit = 1'b0;
  logic v21_sel = 1'b0;
  logic orig_mode = 1'b1;
  logic loopback = 1'b0;
  logic carrier_ok = 1'b1;
  logic rxd;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  fsk_demod #(.CLK_HZ(CLK_HZ)) dut (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .v21_sel(v21_sel),
    .orig_mode(orig_mode), .loopback(loopback), .carrier_ok(carrier_ok), .rxd(rxd)
  );

  // {v21, orig, loopback, expected rxd, half-period[7:0]}
  localparam int NV = 22;
  localparam logic [11:0] VEC [NV] = '{
    {4'b0101, 8'd44},  {4'b0100, 8'd49},   // R2 Bell originate high band
    {4'b0001, 8'd78},  {4'b0000, 8'd93},   // R2 Bell answer low band
    {4'b0111, 8'd78},  {4'b0110, 8'd93},   // R3 Bell originate loopback
    {4'b0011, 8'd44},  {4'b0010, 8'd49},   // R3 Bell answer loopback
    {4'b1101, 8'd60},  {4'b1100, 8'd54},   // R5 V.21 originate
    {4'b1001, 8'd102}, {4'b1000, 8'd84},   // R5 V.21 answer
    {4'b1111, 8'd102}, {4'b1110, 8'd84},   // R3 V.21 originate loopback
    {4'b1011, 8'd60},  {4'b1010, 8'd54},   // R3 V.21 answer loopback
    {4'b0101, 8'd45},  {4'b0100, 8'd47},   // R6 Bell threshold 46
    {4'b0100, 8'd46},                      // R6 Bell tie is space
    {4'b1101, 8'd58},  {4'b1100, 8'd56},   // R6 V.21 threshold 57
    {4'b1100, 8'd57}                       // R6 V.21 tie is space
  };

  task automatic check(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s rxd=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic tone(int h, int n);
    for (int i = 0; i < n; i++) begin
      repeat (h) @(negedge clk);
      rx_bit = ~rx_bit;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic setup(logic v, logic o, logic l);
    v21_sel = v; orig_mode = o; loopback = l;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rxd, 1'b1, "R1 reset mark");
    rx_bit = 1'b1;
    repeat (10) @(negedge clk);
    check(rxd, 1'b1, "R1 first transition ignored");

    for (int k = 0; k < NV; k++) begin
      setup(VEC[k][11], VEC[k][10], VEC[k][9]);
      tone(int'(VEC[k][7:0]), 6);
      check(rxd, VEC[k][8], $sformatf("R4/R5/R6 vector %0d", k));
    end

    // R8: too-long half-period discarded
    setup(1'b0, 1'b1, 1'b0);
    tone(49, 6);
    check(rxd, 1'b0, "R4 space before noise");
    repeat (116) @(negedge clk);
    rx_bit = ~rx_bit;
    repeat (4) @(negedge clk);
    check(rxd, 1'b0, "R8 long gap keeps space");
    tone(44, 6);
    check(rxd, 1'b1, "R4 mark before noise");
    repeat (117) @(negedge clk);
    rx_bit = ~rx_bit;
    repeat (4) @(negedge clk);
    check(rxd, 1'b1, "R8 long gap keeps mark");

    // R8: gap exactly at limit 98 is accepted (space)
    tone(44, 6);
    repeat (94) @(negedge clk);
    rx_bit = ~rx_bit;
    repeat (4) @(negedge clk);
    check(rxd, 1'b0, "R8 limit gap accepted");

    // R9 / R10: clamp and decisions under clamp
    tone(49, 6);
    check(rxd, 1'b0, "R9 space before clamp");
    carrier_ok = 1'b0;
    #1;
    check(rxd, 1'b1, "R9 clamp same cycle");
    tone(44, 6);
    check(rxd, 1'b1, "R9 clamp during mark tone");
    carrier_ok = 1'b1;
    #1;
    check(rxd, 1'b1, "R10 mark decided under clamp");
    carrier_ok = 1'b0;
    tone(49, 6);
    check(rxd, 1'b1, "R9 clamp during space tone");
    carrier_ok = 1'b1;
    #1;
    check(rxd, 1'b0, "R10 space decided under clamp");

    // R1: reset returns decision to mark
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(rxd, 1'b1, "R1 reset after space");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule